// File: doc/BRIEF.md
# Bus Data Phase Sequencer

This block runs the data phase of one transfer for an agent that sources data onto a shared 64-bit data bus. The agent's request logic gives a one-clock start pulse along with a size select. The size is either a full line of four beats or a partial transfer of 1 to 8 bytes in one beat. The sequencer then puts one data word on the bus on each clock where the data source flags a valid word. It raises the data-ready strobe on exactly those clocks.

A clock where the source has nothing ready becomes an idle clock. Data-ready stays low on an idle clock, and the phase goes on. A line transfer holds data-busy from its first beat through its final beat. It then gives up the bus one clock later, and marks that clock with a done pulse. A partial transfer can run as a bare one-clock phase with no data-busy. If the requester asks for it at start, a partial transfer can also hold data-busy for its single beat, and then release the bus one clock after data-busy drops.

Top module: `dphase_seq`

## Requirements
- R1: While reset is held and until the first accepted start, data-ready, data-busy and done are low and the data output is all zeros.
- R2: A start with `line_i` = 1 gives exactly four data-ready clocks. The words appear in the order the source presented them, and a word is taken from `src_data_i` on a clock with the phase active and `src_valid_i` high, then shown in the following clock.
- R3: A start with `line_i` = 0 gives exactly one data-ready clock.
- R4: A clock in an active phase with `src_valid_i` low shows data-ready low in the following clock, does not count as a beat, and does not end the phase.
- R5: In a line transfer, data-busy is high from the first data-ready clock through the final data-ready clock, including idle clocks between beats. It is low before the first beat and after the final one.
- R6: A partial transfer started with `hold_i` = 0 never raises data-busy, and done is high in the same clock as its single data-ready.
- R7: A partial transfer started with `hold_i` = 1 raises data-busy together with its data-ready, and done follows one clock later with data-busy low.
- R8: For every phase that used data-busy, done is high for one clock only, in the first clock after the final data-ready, and data-busy is low in that clock.
- R9: A start presented while a phase is in progress (from the clock after an accepted start up to and including the clock before done is shown) is ignored. A start given in the clock where done is shown is accepted.
- R10: On every clock where data-ready is low, the data output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a data phase; taken only while idle |
| line_i | input | 1 | Size select at start: 1 = four-beat line, 0 = one-beat partial |
| hold_i | input | 1 | At start of a partial transfer: 1 = hold data-busy for the beat |
| src_valid_i | input | 1 | The data source has a word ready this clock |
| src_data_i | input | DATA_W | Word offered by the data source |
| drdy_o | output | 1 | Data-ready: valid word on `data_o` this clock |
| dbsy_o | output | 1 | Data-busy: the bus is held for a multi-clock phase |
| data_o | output | DATA_W | Data bus word, zero when data-ready is low |
| done_o | output | 1 | One-clock pulse on the clock the bus is released |

## Verification
A beat counter that is off by one shows at the ports in the very phase it occurs: a line gets three or five data-ready clocks, or done comes a clock early or late. A stale busy-mode flag makes data-busy appear on a bare partial transfer, or disappear from a held one, in the first beat clock. A state machine that stays active too long shows as a start ignored right after done, so the following phase never makes its first beat. A state machine that leaves too early shows as a new phase starting under the old one. Each of these breaks the per-clock expected stream within one to two clocks of the faulty cycle.

// File: rtl/dphase_pkg.sv
package dphase_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_ACTIVE  = 2'd1,
      PH_RELEASE = 2'd2
   } ph_state_e;

   typedef enum logic {
      XFER_PART = 1'b0,
      XFER_LINE = 1'b1
   } xfer_size_e;

endpackage

// File: rtl/dphase_beat_ctr.sv
module dphase_beat_ctr #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   output logic             last_o
);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= load_val_i;
      end else if (step_i && (remain_q != '0)) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign last_o = (remain_q == CNT_W'(1));

endmodule

// File: rtl/dphase_ctl.sv
module dphase_ctl
   import dphase_pkg::*;
#(
   parameter int LINE_BEATS = 4,
   parameter int CNT_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             line_i,
   input  logic             hold_i,
   input  logic             src_valid_i,
   input  logic             last_i,
   output logic             take_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output logic             drdy_o,
   output logic             dbsy_o,
   output logic             done_o
);

   ph_state_e  state_q;
   xfer_size_e size_sel;
   logic       busy_mode_q;
   logic       drdy_q, dbsy_q, done_q;

   assign size_sel   = xfer_size_e'(line_i);
   assign load_o     = (state_q == PH_IDLE) && start_i;
   assign load_val_o = (size_sel == XFER_LINE) ? CNT_W'(LINE_BEATS) : CNT_W'(1);
   assign take_o     = (state_q == PH_ACTIVE) && src_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PH_IDLE;
         busy_mode_q <= 1'b0;
         drdy_q      <= 1'b0;
         dbsy_q      <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         drdy_q <= 1'b0;
         done_q <= 1'b0;
         case (state_q)
            PH_IDLE: begin
               dbsy_q <= 1'b0;
               if (start_i) begin
                  state_q     <= PH_ACTIVE;
                  busy_mode_q <= (size_sel == XFER_LINE) || hold_i;
               end
            end
            PH_ACTIVE: begin
               if (src_valid_i) begin
                  drdy_q <= 1'b1;
                  if (last_i) begin
                     if (busy_mode_q) begin
                        dbsy_q  <= 1'b1;
                        state_q <= PH_RELEASE;
                     end else begin
                        dbsy_q  <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= PH_IDLE;
                     end
                  end else begin
                     dbsy_q <= busy_mode_q;
                  end
               end
            end
            PH_RELEASE: begin
               dbsy_q  <= 1'b0;
               done_q  <= 1'b1;
               state_q <= PH_IDLE;
            end
            default: state_q <= PH_IDLE;
         endcase
      end
   end

   assign drdy_o = drdy_q;
   assign dbsy_o = dbsy_q;
   assign done_o = done_q;

endmodule

// File: rtl/dphase_data_reg.sv
module dphase_data_reg #(
   parameter int DATA_W    = 64,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);

   logic [DATA_W-1:0] word_q;

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= take_i ? d_i : '0;
         end
      end else begin : g_hold_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      word_q <= '0;
            else if (take_i) word_q <= d_i;
         end
      end
   endgenerate

   assign q_o = word_q;

endmodule

// File: rtl/dphase_seq.sv
module dphase_seq #(
   parameter int DATA_W     = 64,
   parameter int LINE_BEATS = 4,
   parameter bit ZERO_IDLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              line_i,
   input  logic              hold_i,
   input  logic              src_valid_i,
   input  logic [DATA_W-1:0] src_data_i,
   output logic              drdy_o,
   output logic              dbsy_o,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o
);

   localparam int CNT_W = $clog2(LINE_BEATS + 1);

   generate
      if (LINE_BEATS < 2 || LINE_BEATS > 64) begin : g_bad_beats
         $error("dphase_seq: LINE_BEATS must lie in 2..64");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("dphase_seq: DATA_W must be a whole number of bytes");
      end
   endgenerate

   logic             take;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             last;

   dphase_ctl #(
      .LINE_BEATS (LINE_BEATS),
      .CNT_W      (CNT_W)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .line_i      (line_i),
      .hold_i      (hold_i),
      .src_valid_i (src_valid_i),
      .last_i      (last),
      .take_o      (take),
      .load_o      (load),
      .load_val_o  (load_val),
      .drdy_o      (drdy_o),
      .dbsy_o      (dbsy_o),
      .done_o      (done_o)
   );

   dphase_beat_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .step_i     (take),
      .last_o     (last)
   );

   dphase_data_reg #(
      .DATA_W    (DATA_W),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .d_i    (src_data_i),
      .q_o    (data_o)
   );

endmodule

// File: rtl/dphase_seq_chk.sv
module dphase_seq_chk #(
   parameter int DATA_W     = 64,
   parameter int LINE_BEATS = 4,
   parameter bit ZERO_IDLE  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              line_i,
   input logic              drdy_o,
   input logic              dbsy_o,
   input logic [DATA_W-1:0] data_o,
   input logic              done_o
);

   logic in_phase_q;
   int   beats_q;
   int   want_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_phase_q <= 1'b0;
         beats_q    <= 0;
         want_q     <= 0;
      end else if (!in_phase_q || done_o) begin
         in_phase_q <= start_i;
         beats_q    <= 0;
         want_q     <= line_i ? LINE_BEATS : 1;
      end else begin
         beats_q <= beats_q + (drdy_o ? 1 : 0);
      end
   end

   // R2 and R3: beats seen across one phase match its size
   assert_beat_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_phase_q && done_o) |-> ((beats_q + (drdy_o ? 1 : 0)) == want_q));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_busy_drop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dbsy_o) |-> done_o);

   assert_release_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !dbsy_o);

   assert_bare_beat_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (drdy_o && !dbsy_o) |-> done_o);

   assert_no_beat_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drdy_o |-> in_phase_q);

   generate
      if (ZERO_IDLE) begin : g_zero_chk
         assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !drdy_o |-> (data_o == '0));
      end
   endgenerate

endmodule

bind dphase_seq dphase_seq_chk #(
   .DATA_W     (DATA_W),
   .LINE_BEATS (LINE_BEATS),
   .ZERO_IDLE  (ZERO_IDLE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .line_i  (line_i),
   .drdy_o  (drdy_o),
   .dbsy_o  (dbsy_o),
   .data_o  (data_o),
   .done_o  (done_o)
);

// File: tb/dphase_seq_test.sv
`timescale 1ns/1ps
module dphase_seq_test;

   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          line_i = 1'b0;
   logic          hold_i = 1'b0;
   logic          src_valid_i = 1'b0;
   logic [DW-1:0] src_data_i = '0;
   logic          drdy_o, dbsy_o, done_o;
   logic [DW-1:0] data_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;
   logic [DW-1:0] next_word = 64'h0123_4567_89AB_0000;

   int            exp_cyc[$];
   logic [2:0]    exp_ctl[$];
   logic [DW-1:0] exp_dat[$];
   string         exp_req[$];

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   dphase_seq uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .line_i      (line_i),
      .hold_i      (hold_i),
      .src_valid_i (src_valid_i),
      .src_data_i  (src_data_i),
      .drdy_o      (drdy_o),
      .dbsy_o      (dbsy_o),
      .data_o      (data_o),
      .done_o      (done_o)
   );

   // expectation for the clock after the coming edge: {drdy, dbsy, done}
   task automatic expect_next(input logic r, input logic b, input logic d,
                              input logic [DW-1:0] w, input string req);
      exp_cyc.push_back(cyc + 1);
      exp_ctl.push_back({r, b, d});
      exp_dat.push_back(w);
      exp_req.push_back(req);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // monitor: compares outputs against the scoreboard in mid-cycle
   always @(negedge clk) begin
      while (exp_cyc.size() > 0 && exp_cyc[0] <= cyc) begin
         checks++;
         if (exp_cyc[0] != cyc ||
             {drdy_o, dbsy_o, done_o} != exp_ctl[0] || data_o != exp_dat[0]) begin
            errors++;
            $display("FAIL %s cycle %0d: got drdy/dbsy/done=%b data=%h, expected %b data=%h",
                     exp_req[0], cyc, {drdy_o, dbsy_o, done_o}, data_o,
                     exp_ctl[0], exp_dat[0]);
         end
         void'(exp_cyc.pop_front());
         void'(exp_ctl.pop_front());
         void'(exp_dat.pop_front());
         void'(exp_req.pop_front());
      end
   end

   // vmask bit i: source valid on the i-th clock after the start clock
   task automatic run_phase(input bit line, input bit hold,
                            input logic [15:0] vmask, input bit back2back);
      int  need = line ? 4 : 1;
      bit  busy = line | hold;
      int  got  = 0;
      bit  seen = 1'b0;
      string tag = line ? "R2/R5" : (hold ? "R3/R7" : "R3/R6");
      step();
      start_i = 1'b1; line_i = line; hold_i = hold;
      src_valid_i = 1'b1; src_data_i = 64'hDEAD_BEEF_0000_0001;
      expect_next(1'b0, 1'b0, 1'b0, '0, "R9/R10 start clock");
      for (int i = 0; got < need; i++) begin
         bit v = (i < 16) ? vmask[i] : 1'b1;
         logic eb, ed;
         step();
         start_i = 1'b1;          // R9: ignored while busy
         line_i  = ~line;         // size changes mid-phase have no effect
         hold_i  = ~hold;
         src_valid_i = v;
         src_data_i  = next_word;
         eb = v ? busy : (seen & busy);
         ed = v && (got == need - 1) && !busy;
         if (v) expect_next(1'b1, eb, ed, next_word, tag);
         else   expect_next(1'b0, eb, 1'b0, '0, "R4/R5/R10 idle clock");
         next_word = next_word + 64'h1_0001;
         if (v) begin
            got++;
            seen = 1'b1;
         end
      end
      if (busy) begin
         step();
         start_i = 1'b1; src_valid_i = 1'b1;
         expect_next(1'b0, 1'b0, 1'b1, '0, "R8 release clock");
      end
      if (!back2back) begin
         step();
         start_i = 1'b0; src_valid_i = 1'b1;
         expect_next(1'b0, 1'b0, 1'b0, '0, "R9 no phase after done");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (drdy_o !== 1'b0 || dbsy_o !== 1'b0 || done_o !== 1'b0 || data_o !== '0) begin
         errors++;
         $display("FAIL R1 reset: got drdy/dbsy/done=%b data=%h, expected 000 data=0",
                  {drdy_o, dbsy_o, done_o}, data_o);
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      step();
      expect_next(1'b0, 1'b0, 1'b0, '0, "R1 idle after reset");

      run_phase(1'b1, 1'b0, 16'hFFFF, 1'b0);   // plain line
      run_phase(1'b0, 1'b0, 16'hFFFF, 1'b0);   // bare partial
      run_phase(1'b0, 1'b1, 16'hFFFF, 1'b0);   // partial holding busy
      run_phase(1'b1, 1'b0, 16'hFFD2, 1'b0);   // line with idle clocks
      run_phase(1'b0, 1'b0, 16'hFFF8, 1'b0);   // partial after three idles
      run_phase(1'b0, 1'b1, 16'hFFFC, 1'b1);   // held partial, then start at done
      run_phase(1'b1, 1'b0, 16'hFFFF, 1'b1);   // line, then start at done
      run_phase(1'b0, 1'b0, 16'hFFFE, 1'b0);

      step();
      start_i = 1'b0; src_valid_i = 1'b0;
      repeat (4) step();
      if (exp_cyc.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R2 scoreboard: got %0d items left, expected 0", exp_cyc.size());
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got a hung run, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule